// File: doc/BRIEF.md
# Dual-Stage Operand Forwarding Unit

This block decides, for every register operand that a five-stage integer pipeline consumes early, where that operand's value should come from this cycle. The pipeline resolves branches in the decode stage, so two consumers need fresh data: the ALU operands of the instruction in execute and the comparator operands of the branch in decode. For each of those four operands the block compares the source register index against the destination index of the instructions currently in the memory and write-back stages. It then emits a 2-bit select that the surrounding operand multiplexers use.

The block is purely combinational and holds no state. Each operand is resolved on its own, so the two operands of one stage may pick different producers in the same cycle. The decode-side selects follow exactly the same rules as the execute-side selects. A branch that depends on a result now being written back can therefore compare in the same cycle without waiting for the register file. Stall generation, the multiplexers and the register file are outside this block.

Top module: `dual_fwd_unit`

## Requirements
- R1: Every select uses the encoding 0 = register file, 1 = memory-stage result, 2 = write-back-stage result, and the value 3 never appears.
- R2: A select is 1 when the memory stage has its write enable high and its destination index equals that operand's nonzero source index.
- R3: A select is 2 when the write-back stage has its write enable high and its destination index equals that operand's nonzero source index, and the memory stage does not also match.
- R4: When both the memory and write-back stages match the same operand, the select is 1, because the memory stage holds the newer result.
- R5: A stage whose write enable is low never causes forwarding, even when its destination index equals the source index.
- R6: An operand whose source index is 0 always gets select 0, whatever the destination indices and enables are.
- R7: The two operands of one stage are resolved independently; in the same cycle, the first operand may take write-back data while the second takes memory data.
- R8: The decode-stage selects (`id_sel_a`, `id_sel_b`) obey R1 to R7 with the decode source indices, independently of the execute-stage selects. Equal source indices in both stages give equal selects.
- R9: All selects depend only on the present inputs. The same input pattern always produces the same selects, whatever came before, and the result is valid in the same cycle the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | First source register index of the instruction in execute |
| ex_src_b | input | 5 | Second source register index of the instruction in execute |
| id_src_a | input | 5 | First source register index of the branch in decode |
| id_src_b | input | 5 | Second source register index of the branch in decode |
| mem_dst | input | 5 | Destination register index of the instruction in the memory stage |
| mem_wr_en | input | 1 | Register-write enable of the instruction in the memory stage |
| wb_dst | input | 5 | Destination register index of the instruction in write-back |
| wb_wr_en | input | 1 | Register-write enable of the instruction in write-back |
| ex_sel_a | output | 2 | Source select for the first ALU operand |
| ex_sel_b | output | 2 | Source select for the second ALU operand |
| id_sel_a | output | 2 | Source select for the first branch-comparator operand |
| id_sel_b | output | 2 | Source select for the second branch-comparator operand |

## Verification
All four selects are due in the same cycle as the indices and enables that produce them, with zero register delay. The driver applies each pattern just after a rising edge and queues the four expected selects. The monitor compares them at the following falling edge, while the inputs are still held, so every result is read half a period after its stimulus. Directed patterns cover priority, disabled stages, register 0 and mixed per-operand sources. A pattern is also repeated after unrelated ones to show that no history leaks in, and a long run of biased random patterns follows.

// File: rtl/dual_fwd_pkg.sv
package dual_fwd_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_REGFILE = 2'd0,
        SRC_MEM     = 2'd1,
        SRC_WB      = 2'd2
    } fwd_src_e;

endpackage

// File: rtl/dual_fwd_operand.sv
module dual_fwd_operand
    import dual_fwd_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] src_idx,
    input  logic [IDX_W-1:0] mem_dst,
    input  logic             mem_wr_en,
    input  logic [IDX_W-1:0] wb_dst,
    input  logic             wb_wr_en,
    output logic [SEL_W-1:0] sel
);

    localparam logic [IDX_W-1:0] ZERO_IDX = '0;

    logic     src_live;
    logic     mem_hit;
    logic     wb_hit;
    fwd_src_e choice;

    // register 0 is constant, so it never takes a forwarded value
    assign src_live = (src_idx != ZERO_IDX);
    assign mem_hit  = src_live && mem_wr_en && (mem_dst == src_idx);
    assign wb_hit   = src_live && wb_wr_en  && (wb_dst  == src_idx);

    // the younger producer (memory stage) takes precedence
    always_comb begin
        unique case ({mem_hit, wb_hit})
            2'b10, 2'b11: choice = SRC_MEM;
            2'b01:        choice = SRC_WB;
            default:      choice = SRC_REGFILE;
        endcase
    end

    assign sel = choice;

endmodule

// File: rtl/dual_fwd_stage.sv
module dual_fwd_stage
    import dual_fwd_pkg::*;
#(
    parameter int IDX_W   = 5,
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0][IDX_W-1:0] src_idx,
    input  logic [IDX_W-1:0]              mem_dst,
    input  logic                          mem_wr_en,
    input  logic [IDX_W-1:0]              wb_dst,
    input  logic                          wb_wr_en,
    output logic [NUM_SRC-1:0][SEL_W-1:0] sel
);

    for (genvar op = 0; op < NUM_SRC; op++) begin : g_operand
        dual_fwd_operand #(
            .IDX_W (IDX_W)
        ) u_operand (
            .src_idx   (src_idx[op]),
            .mem_dst   (mem_dst),
            .mem_wr_en (mem_wr_en),
            .wb_dst    (wb_dst),
            .wb_wr_en  (wb_wr_en),
            .sel       (sel[op])
        );
    end

endmodule

// File: rtl/dual_fwd_unit.sv
module dual_fwd_unit
    import dual_fwd_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] ex_src_a,
    input  logic [IDX_W-1:0] ex_src_b,
    input  logic [IDX_W-1:0] id_src_a,
    input  logic [IDX_W-1:0] id_src_b,
    input  logic [IDX_W-1:0] mem_dst,
    input  logic             mem_wr_en,
    input  logic [IDX_W-1:0] wb_dst,
    input  logic             wb_wr_en,
    output logic [1:0]       ex_sel_a,
    output logic [1:0]       ex_sel_b,
    output logic [1:0]       id_sel_a,
    output logic [1:0]       id_sel_b
);

    localparam int OPS_PER_STAGE = 2;

    logic [OPS_PER_STAGE-1:0][IDX_W-1:0] ex_src;
    logic [OPS_PER_STAGE-1:0][IDX_W-1:0] id_src;
    logic [OPS_PER_STAGE-1:0][SEL_W-1:0] ex_sel;
    logic [OPS_PER_STAGE-1:0][SEL_W-1:0] id_sel;

    assign ex_src = {ex_src_b, ex_src_a};
    assign id_src = {id_src_b, id_src_a};

    // execute-stage path: ALU operands
    dual_fwd_stage #(
        .IDX_W   (IDX_W),
        .NUM_SRC (OPS_PER_STAGE)
    ) u_ex_path (
        .src_idx   (ex_src),
        .mem_dst   (mem_dst),
        .mem_wr_en (mem_wr_en),
        .wb_dst    (wb_dst),
        .wb_wr_en  (wb_wr_en),
        .sel       (ex_sel)
    );

    // decode-stage path: early branch comparator operands
    dual_fwd_stage #(
        .IDX_W   (IDX_W),
        .NUM_SRC (OPS_PER_STAGE)
    ) u_id_path (
        .src_idx   (id_src),
        .mem_dst   (mem_dst),
        .mem_wr_en (mem_wr_en),
        .wb_dst    (wb_dst),
        .wb_wr_en  (wb_wr_en),
        .sel       (id_sel)
    );

    assign ex_sel_a = ex_sel[0];
    assign ex_sel_b = ex_sel[1];
    assign id_sel_a = id_sel[0];
    assign id_sel_b = id_sel[1];

endmodule

// File: rtl/dual_fwd_unit_chk.sv
module dual_fwd_unit_chk #(
    parameter int IDX_W = 5
) (
    input logic [IDX_W-1:0] ex_src_a,
    input logic [IDX_W-1:0] ex_src_b,
    input logic [IDX_W-1:0] id_src_a,
    input logic [IDX_W-1:0] id_src_b,
    input logic [IDX_W-1:0] mem_dst,
    input logic             mem_wr_en,
    input logic [IDX_W-1:0] wb_dst,
    input logic             wb_wr_en,
    input logic [1:0]       ex_sel_a,
    input logic [1:0]       ex_sel_b,
    input logic [1:0]       id_sel_a,
    input logic [1:0]       id_sel_b
);

    always_comb begin
        assert_no_code3_R1: assert (ex_sel_a != 2'd3 && ex_sel_b != 2'd3 &&
                                    id_sel_a != 2'd3 && id_sel_b != 2'd3)
            else $error("select value 3 observed");

        assert_zero_src_R6: assert ((ex_src_a != '0 || ex_sel_a == 2'd0) &&
                                    (ex_src_b != '0 || ex_sel_b == 2'd0) &&
                                    (id_src_a != '0 || id_sel_a == 2'd0) &&
                                    (id_src_b != '0 || id_sel_b == 2'd0))
            else $error("register 0 was forwarded");

        assert_idle_stages_R5: assert ((mem_wr_en || wb_wr_en) ||
                                       (ex_sel_a == 2'd0 && ex_sel_b == 2'd0 &&
                                        id_sel_a == 2'd0 && id_sel_b == 2'd0))
            else $error("forwarding with both write enables low");

        assert_mem_needs_en_R2: assert (mem_wr_en ||
                                        (ex_sel_a != 2'd1 && ex_sel_b != 2'd1 &&
                                         id_sel_a != 2'd1 && id_sel_b != 2'd1))
            else $error("memory forward while memory stage not writing");

        assert_wb_needs_en_R3: assert (wb_wr_en ||
                                       (ex_sel_a != 2'd2 && ex_sel_b != 2'd2 &&
                                        id_sel_a != 2'd2 && id_sel_b != 2'd2))
            else $error("write-back forward while write-back stage not writing");

        assert_mem_wins_R4: assert (!(mem_wr_en && wb_wr_en && mem_dst == wb_dst &&
                                      ex_src_a == mem_dst && ex_src_a != '0) ||
                                    ex_sel_a == 2'd1)
            else $error("write-back chosen over memory stage");

        assert_stage_match_R8: assert ((ex_src_a != id_src_a || ex_sel_a == id_sel_a) &&
                                       (ex_src_b != id_src_b || ex_sel_b == id_sel_b))
            else $error("decode and execute disagree for equal sources");

        assert_operand_indep_R7: assert ((ex_src_a != ex_src_b || ex_sel_a == ex_sel_b) &&
                                         (id_src_a != id_src_b || id_sel_a == id_sel_b))
            else $error("equal operands resolved differently");
    end

endmodule

bind dual_fwd_unit dual_fwd_unit_chk #(
    .IDX_W (IDX_W)
) u_chk (
    .ex_src_a  (ex_src_a),
    .ex_src_b  (ex_src_b),
    .id_src_a  (id_src_a),
    .id_src_b  (id_src_b),
    .mem_dst   (mem_dst),
    .mem_wr_en (mem_wr_en),
    .wb_dst    (wb_dst),
    .wb_wr_en  (wb_wr_en),
    .ex_sel_a  (ex_sel_a),
    .ex_sel_b  (ex_sel_b),
    .id_sel_a  (id_sel_a),
    .id_sel_b  (id_sel_b)
);

// File: tb/dual_fwd_unit_test.sv
module dual_fwd_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 5;
    localparam int N_RANDOM   = 2000;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic [IDX_W-1:0] ex_src_a = '0, ex_src_b = '0, id_src_a = '0, id_src_b = '0;
    logic [IDX_W-1:0] mem_dst = '0, wb_dst = '0;
    logic             mem_wr_en = 1'b0, wb_wr_en = 1'b0;
    logic [1:0]       ex_sel_a, ex_sel_b, id_sel_a, id_sel_b;

    int checks = 0;
    int fails  = 0;
    bit drive_done = 1'b0;

    typedef struct {
        logic [1:0] ea, eb, ia, ib;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    dual_fwd_unit #(.IDX_W(IDX_W)) uut (
        .ex_src_a  (ex_src_a),
        .ex_src_b  (ex_src_b),
        .id_src_a  (id_src_a),
        .id_src_b  (id_src_b),
        .mem_dst   (mem_dst),
        .mem_wr_en (mem_wr_en),
        .wb_dst    (wb_dst),
        .wb_wr_en  (wb_wr_en),
        .ex_sel_a  (ex_sel_a),
        .ex_sel_b  (ex_sel_b),
        .id_sel_a  (id_sel_a),
        .id_sel_b  (id_sel_b)
    );

    // reference model written from the requirements
    function automatic logic [1:0] model(input logic [IDX_W-1:0] s,
                                         input logic [IDX_W-1:0] md, input logic me,
                                         input logic [IDX_W-1:0] wd, input logic we);
        if (s == '0)                return 2'd0;  // R6
        if (me && md == s)          return 2'd1;  // R2, R4
        if (we && wd == s)          return 2'd2;  // R3
        return 2'd0;                              // R5
    endfunction

    task automatic drive(input logic [IDX_W-1:0] ea, input logic [IDX_W-1:0] eb,
                         input logic [IDX_W-1:0] ia, input logic [IDX_W-1:0] ib,
                         input logic [IDX_W-1:0] md, input logic me,
                         input logic [IDX_W-1:0] wd, input logic we,
                         input string tag);
        exp_t it;
        @(posedge clk);
        ex_src_a = ea; ex_src_b = eb; id_src_a = ia; id_src_b = ib;
        mem_dst = md; mem_wr_en = me; wb_dst = wd; wb_wr_en = we;
        it.ea  = model(ea, md, me, wd, we);
        it.eb  = model(eb, md, me, wd, we);
        it.ia  = model(ia, md, me, wd, we);
        it.ib  = model(ib, md, me, wd, we);
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic cmp(input string name, input logic [1:0] act,
                       input logic [1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, name, act, exp);
        end
    endtask

    // monitor: results are due in the same cycle, read at the falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            cmp("ex_sel_a", ex_sel_a, it.ea, it.tag);
            cmp("ex_sel_b", ex_sel_b, it.eb, it.tag);
            cmp("id_sel_a", id_sel_a, it.ia, it.tag);
            cmp("id_sel_b", id_sel_b, it.ib, it.tag);
        end
    end

    function automatic logic [IDX_W-1:0] pick_idx();
        // small range so that matches are frequent
        return IDX_W'($urandom_range(0, 3));
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // reset-state pattern: all zero inputs give register-file selects (R1)
        drive(5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, "R1");
        // memory stage match on execute operand a
        drive(5'd10, 5'd1, 5'd3, 5'd4, 5'd10, 1'b1, 5'd20, 1'b1, "R2");
        // write-back match only
        drive(5'd7, 5'd6, 5'd9, 5'd8, 5'd30, 1'b1, 5'd7, 1'b1, "R3");
        // both stages write the same register: memory wins
        drive(5'd7, 5'd7, 5'd7, 5'd7, 5'd7, 1'b1, 5'd7, 1'b1, "R4");
        // write enables low with matching indices: no forwarding
        drive(5'd5, 5'd5, 5'd5, 5'd5, 5'd5, 1'b0, 5'd5, 1'b0, "R5");
        // memory disabled, write-back enabled: write-back takes over
        drive(5'd5, 5'd2, 5'd5, 5'd2, 5'd5, 1'b0, 5'd5, 1'b1, "R5");
        // register 0 with enabled matching producers
        drive(5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, "R6");
        // operand a from write-back, operand b from memory
        drive(5'd6, 5'd7, 5'd12, 5'd13, 5'd7, 1'b1, 5'd6, 1'b1, "R7");
        // decode path independent: decode uses different producers than execute
        drive(5'd1, 5'd2, 5'd7, 5'd6, 5'd6, 1'b1, 5'd7, 1'b1, "R8");
        // write-back to decode branch operand with no memory match
        drive(5'd3, 5'd3, 5'd7, 5'd28, 5'd11, 1'b1, 5'd7, 1'b1, "R8");
        // history-free: pattern, unrelated pattern, pattern again
        drive(5'd9, 5'd10, 5'd9, 5'd10, 5'd9, 1'b1, 5'd10, 1'b1, "R9");
        drive(5'd31, 5'd31, 5'd1, 5'd1, 5'd1, 1'b0, 5'd31, 1'b1, "R9");
        drive(5'd9, 5'd10, 5'd9, 5'd10, 5'd9, 1'b1, 5'd10, 1'b1, "R9");

        for (int n = 0; n < N_RANDOM; n++) begin
            drive(pick_idx(), pick_idx(), pick_idx(), pick_idx(),
                  pick_idx(), 1'($urandom_range(0, 1)),
                  pick_idx(), 1'($urandom_range(0, 1)), "R7");
        end

        @(posedge clk);
        @(posedge clk);
        drive_done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (drive_done && sb.size() == 0);
            end
            begin
                repeat (WATCHDOG) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule